// File: doc/BRIEF.md
# Prime-Modulus Bank Address Mapper

This block turns a linear word address into a bank index and a word offset inside that bank, for a memory built from a prime number of banks. The bank index is the address reduced modulo the prime bank count. The offset is the address reduced modulo the bank depth, which is a power of two, so the offset is simply the low address bits. The two moduli are coprime, so every address below their product lands on its own bank/offset pair. Accesses that walk memory with a power-of-two stride therefore rotate through all banks instead of hammering one.

The reduction by the prime is done by a bit-serial remainder unit that consumes one address bit per clock. The latency is therefore fixed at `ADDR_W` cycles from acceptance. Requests enter and results leave through valid/ready handshakes. Only one request is in flight at a time, so results come back in request order. An address at or beyond the mapped range is not folded back onto a real location. It is reported with an error flag, and its bank and offset outputs are zero.

Top module: `prime_bank_mapper`

## Requirements
- R1: For an accepted address `a` below `NUM_BANKS * 2**OFS_W`, `res_bank` equals `a mod NUM_BANKS`.
- R2: For such an address, `res_offset` equals `a mod 2**OFS_W`, which is the low `OFS_W` address bits.
- R3: For an address at or above `NUM_BANKS * 2**OFS_W`, `res_err` is 1 and both `res_bank` and `res_offset` are 0. For in-range addresses `res_err` is 0.
- R4: `res_valid` rises exactly `ADDR_W` clock edges after the edge on which the request is accepted.
- R5: `req_ready` is high only while no request is in flight or waiting to be taken. After an acceptance it stays low until the result has been taken.
- R6: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_bank`, `res_offset` and `res_err` hold their values.
- R7: Over the range `[0, NUM_BANKS * 2**OFS_W)`, no two addresses give the same bank/offset pair, and every pair occurs.
- R8: For any base `b` below `2**OFS_W`, the `NUM_BANKS` addresses `b + k*2**OFS_W` (k = 0 .. NUM_BANKS-1) map to `NUM_BANKS` distinct banks.
- R9: After reset, `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| req_valid | input | 1 | Request address is present |
| req_ready | output | 1 | Mapper can take a request |
| req_addr | input | ADDR_W | Linear word address |
| res_valid | output | 1 | Result is present |
| res_ready | input | 1 | Consumer takes the result |
| res_bank | output | BANK_W | Bank index, `a mod NUM_BANKS` |
| res_offset | output | OFS_W | Word offset inside the bank |
| res_err | output | 1 | Address lies outside the mapped range |

## Verification
The assertions assume that `NUM_BANKS` is prime, that `OFS_W` is at least 1, and that the environment keeps `req_addr` steady while a request waits to be accepted. They also assume that the consumer raises `res_ready` only as a single-cycle acceptance. The bench drives every address of the 8-bit space in turn and changes `req_addr` only on falling edges while `req_ready` is high. It varies the delay before taking each result, so the hold rule is exercised without ever breaking these assumptions.

// File: rtl/pbm_pkg.sv
package pbm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_HOLD = 2'd2
  } pbm_state_e;
endpackage

// File: rtl/pbm_mod_step.sv
// One restoring step of a bit-serial remainder by a constant divisor.
module pbm_mod_step #(
  parameter int DIVISOR = 7,
  parameter int RW      = 3
) (
  input  logic [RW-1:0] rem_i,
  input  logic          bit_i,
  output logic [RW-1:0] rem_o
);
  localparam logic [RW:0] DIV_V = (RW+1)'(DIVISOR);
  logic [RW:0] trial;

  always_comb begin
    trial = {rem_i, bit_i};
    if (trial >= DIV_V) rem_o = RW'(trial - DIV_V);
    else                rem_o = trial[RW-1:0];
  end
endmodule

// File: rtl/pbm_reducer.sv
// Iterative modulo unit: one address bit per cycle, MSB first.
module pbm_reducer #(
  parameter int ADDR_W  = 8,
  parameter int DIVISOR = 7,
  parameter int RW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              last_o,
  output logic [RW-1:0]     rem_o
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic [ADDR_W-1:0] sh_q, sh_d;
  logic [RW-1:0]     rem_q, rem_d, rem_step;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              run;

  assign run = (cnt_q != '0);

  pbm_mod_step #(.DIVISOR(DIVISOR), .RW(RW)) u_step (
    .rem_i (rem_q),
    .bit_i (sh_q[ADDR_W-1]),
    .rem_o (rem_step)
  );

  always_comb begin
    sh_d  = sh_q;
    rem_d = rem_q;
    cnt_d = cnt_q;
    if (start_i) begin
      sh_d  = addr_i;
      rem_d = '0;
      cnt_d = CNT_W'(ADDR_W);
    end else if (run) begin
      sh_d  = {sh_q[ADDR_W-2:0], 1'b0};
      rem_d = rem_step;
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      rem_q <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
    end
  end

  assign last_o = (cnt_q == CNT_W'(1));
  assign rem_o  = rem_q;

  // R1
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rem_q < RW'(DIVISOR));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (cnt_q == CNT_W'(ADDR_W)));
endmodule

// File: rtl/pbm_range_chk.sv
// Flags addresses outside [0, NUM_BANKS * 2**OFS_W).
module pbm_range_chk #(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 7,
  parameter int OFS_W     = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              out_of_range_o
);
  localparam longint SPAN   = longint'(NUM_BANKS) << OFS_W;
  localparam longint ASPACE = longint'(1) << ADDR_W;

  generate
    if (SPAN >= ASPACE) begin : g_full
      assign out_of_range_o = 1'b0;
    end else begin : g_cmp
      localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(SPAN);
      assign out_of_range_o = (addr_i >= LIMIT);
    end
  endgenerate
endmodule

// File: rtl/prime_bank_mapper.sv
module prime_bank_mapper
  import pbm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 7,
  parameter int OFS_W     = 4,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [BANK_W-1:0] res_bank,
  output logic [OFS_W-1:0]  res_offset,
  output logic              res_err
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  pbm_state_e        st_q, st_d;
  logic              accept, last, oor;
  logic [BANK_W-1:0] rem;
  logic [OFS_W-1:0]  ofs_q, ofs_d;
  logic              err_q, err_d;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  pbm_range_chk #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS), .OFS_W(OFS_W)) u_range (
    .addr_i         (req_addr),
    .out_of_range_o (oor)
  );

  pbm_reducer #(.ADDR_W(ADDR_W), .DIVISOR(NUM_BANKS), .RW(BANK_W)) u_red (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (accept),
    .addr_i  (req_addr),
    .last_o  (last),
    .rem_o   (rem)
  );

  always_comb begin
    st_d  = st_q;
    ofs_d = ofs_q;
    err_d = err_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d  = ST_BUSY;
        ofs_d = oor ? '0 : req_addr[OFS_W-1:0];
        err_d = oor;
      end
      ST_BUSY: if (last) st_d = ST_HOLD;
      ST_HOLD: if (res_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      st_q  <= ST_IDLE;
      ofs_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ofs_q <= ofs_d;
      err_q <= err_d;
    end
  end

  assign res_valid  = (st_q == ST_HOLD);
  assign res_bank   = err_q ? '0 : rem;
  assign res_offset = ofs_q;
  assign res_err    = err_q;

  // R3
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_valid && res_err) |-> (res_bank == '0 && res_offset == '0));

  // R5
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> !req_ready);

  // R5
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(req_ready && res_valid));

  // R6
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_bank) &&
                                   $stable(res_offset) && $stable(res_err)));

  // R1
  bank_range_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    res_valid |-> (res_bank < BANK_W'(NUM_BANKS)));
endmodule

// File: tb/prime_bank_mapper_tb.sv
module prime_bank_mapper_tb;
  localparam int ADDR_W = 8;
  localparam int NB     = 7;
  localparam int OW     = 4;
  localparam int DEPTH  = 1 << OW;
  localparam int SPAN   = NB * DEPTH;
  localparam int BW     = $clog2(NB);

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, res_valid, res_ready, res_err;
  logic [ADDR_W-1:0] req_addr;
  logic [BW-1:0] res_bank;
  logic [OW-1:0] res_offset;

  int checks = 0;
  int fails  = 0;
  logic [DEPTH-1:0] seen [NB];
  int bank_of [SPAN];

  always #5 clk = ~clk;

  prime_bank_mapper #(.ADDR_W(ADDR_W), .NUM_BANKS(NB), .OFS_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_bank(res_bank), .res_offset(res_offset), .res_err(res_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(input int a, input int hold);
    int n;
    int eb, eo, ee;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!res_valid && n < 100) begin
      @(posedge clk); @(negedge clk); n++;
    end
    chk(n == ADDR_W, "R4 latency", n, ADDR_W);
    ee = (a >= SPAN) ? 1 : 0;
    eb = ee ? 0 : a % NB;
    eo = ee ? 0 : a % DEPTH;
    for (int h = 0; h < hold; h++) begin
      @(posedge clk); @(negedge clk);
    end
    if (hold > 0) begin
      chk(res_valid && !req_ready, "R5/R6 held valid", int'(res_valid), 1);
    end
    chk(int'(res_err) == ee, "R3 err flag", int'(res_err), ee);
    chk(int'(res_bank) == eb, ee ? "R3 bank zero" : "R1 bank", int'(res_bank), eb);
    chk(int'(res_offset) == eo, ee ? "R3 offset zero" : "R2 offset", int'(res_offset), eo);
    if (!ee) begin
      chk(!seen[res_bank][res_offset], "R7 unique pair", a, -1);
      seen[res_bank][res_offset] = 1'b1;
      bank_of[a] = int'(res_bank);
    end
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && req_ready, "R5 ready after take", int'(req_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; res_ready = 1'b0; req_addr = '0;
    for (int b = 0; b < NB; b++) seen[b] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready && !res_valid, "R9 reset state", int'(req_ready), 1);
    for (int a = 0; a < (1 << ADDR_W); a++) run_one(a, a % 4);
    for (int b = 0; b < NB; b++)
      chk(&seen[b], "R7 all pairs covered", b, DEPTH);
    for (int base = 0; base < DEPTH; base++) begin
      logic [NB-1:0] m;
      m = '0;
      for (int k = 0; k < NB; k++) m[bank_of[base + k*DEPTH]] = 1'b1;
      chk(&m, "R8 stride spread", int'(m), (1 << NB) - 1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule